// File: doc/BRIEF.md
# Nonvolatile RAM Access Port Controller

This block is the byte-wide SRAM front end of a nonvolatile memory. It samples asynchronous-style, active-low select, write-strobe, output-enable and store-busy pins through a two-flop synchronizer. From those pins it decodes whether the cycle is idle, a read, a write or inhibited. It holds a 2048-byte array in registers. A read drives the addressed byte onto a split data bus and raises an output-enable. A write captures address and data while the strobe is low and commits them on the strobe's closing edge.

A store or recall sequencer outside the block supplies two flags: one that marks an active nonvolatile cycle, and one that reports the capacitor supply below its switch threshold. The block also watches the shared store-busy line. A write that is already open when store-busy falls gets a bounded grace window to close. A write that opens while store-busy is low is refused. Every committed write produces a one-cycle strobe, which the sequencer uses to keep its "array modified" flag.

Top module: `nvp_port`

## Requirements
- R1: With select low, output-enable low, write strobe high, store-busy high and no nonvolatile cycle active, `dq_oe_o` is 1 and `dq_o` carries the byte stored at `addr_i`.
- R2: A write opens when select and write strobe are both low, whatever output-enable does. It commits the captured byte on the first rising edge of either pin, and `wr_done_o` is high for exactly one cycle per commit.
- R3: With select high, `dq_oe_o` is 0.
- R4: With store-busy low, `dq_oe_o` is 0 regardless of output-enable.
- R5: If the write strobe is already low when select falls, `dq_oe_o` stays 0 until select returns high, even if the write strobe rises and output-enable is low.
- R6: If store-busy falls while a write is open, that write still commits if it closes within `GRACE_CYC` synchronized cycles. Otherwise it is discarded and no commit pulse is produced.
- R7: A write whose strobe opens while store-busy is low is not performed, even if store-busy returns high before the strobe closes. The target byte is unchanged and no commit pulse is produced.
- R8: While `low_v_i` is 1, no write opens or commits.
- R9: While `nv_busy_i` is 1, `dq_oe_o` is 0 and no write opens or commits.
- R10: All 11 address bits decode: bytes 0x000 and 0x7FF are distinct locations.
- R11: After reset every byte reads 0x00, and `dq_oe_o` and `wr_done_o` are 0.
- R12: Pin inputs reach the decode through two register stages. A pin change driven between two rising edges shows at the outputs after the second following rising edge, not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 11 | Byte address |
| dq_i | input | 8 | Write data from the shared bus |
| dq_o | output | 8 | Read data toward the shared bus |
| dq_oe_o | output | 1 | Drive enable for `dq_o` (0 = high impedance) |
| ce_n_i | input | 1 | Chip select, active low |
| we_n_i | input | 1 | Write strobe, active low |
| oe_n_i | input | 1 | Output enable, active low |
| busy_n_i | input | 1 | Store-busy line, active low |
| nv_busy_i | input | 1 | Nonvolatile store or recall cycle active |
| low_v_i | input | 1 | Capacitor supply below switch threshold |
| wr_done_o | output | 1 | One-cycle pulse per committed write |

## Verification
The bench drives pins on falling clock edges. A level result such as `dq_oe_o` or `dq_o` is due after the second following rising edge, so the bench samples it at the falling edge two cycles later. For R12 it also samples one cycle earlier to confirm the level is not yet there. A commit strobe is due two rising edges after the closing pin edge and is gone one edge later, so the bench samples both instants. Grace-window scenarios count every `wr_done_o` sample across the window. Every write result is then confirmed by a read issued after the busy or flag condition has cleared.

// File: rtl/nvp_pkg.sv
package nvp_pkg;
  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic busy_n;
  } ctl_t;

  typedef enum logic [1:0] {
    M_IDLE,
    M_READ,
    M_WRITE,
    M_INHIBIT
  } mode_e;
endpackage

// File: rtl/nvp_sync.sv
module nvp_sync #(
  parameter int unsigned W = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar gi = 0; gi < STAGES; gi++) begin : g_stage
    logic [W-1:0] src;
    if (gi == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stg_q[gi-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg_q[gi] <= RST_VAL;
      else        stg_q[gi] <= src;
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/nvp_array.sv
module nvp_array #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];

  // R2
  commit_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/nvp_ctrl.sv
module nvp_ctrl
  import nvp_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8,
  parameter int unsigned GRACE_CYC = 125
) (
  input  logic          clk,
  input  logic          rst_n,
  input  ctl_t          ctl_i,
  input  logic          nv_busy_i,
  input  logic          low_v_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          rd_en_o,
  output logic          commit_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o
);
  localparam int unsigned CW = $clog2(GRACE_CYC + 1);
  localparam logic [CW-1:0] G_LAST = CW'(GRACE_CYC - 1);

  mode_e         mode;
  logic          strobe_hi, allow, w_start, w_end, grace_hit, hold_en;
  logic          wr_act_q, wr_act_d;
  logic          strobe_q, ce_q;
  logic          blind_q, blind_d;
  logic [CW-1:0] grace_q, grace_d;
  logic [AW-1:0] hold_addr_q;
  logic [DW-1:0] hold_data_q;

  always_comb begin
    strobe_hi = ctl_i.ce_n | ctl_i.we_n;
    allow     = ctl_i.busy_n & ~nv_busy_i & ~low_v_i;
    w_start   = strobe_q & ~strobe_hi & allow;
    w_end     = wr_act_q & strobe_hi;
    grace_hit = wr_act_q & ~strobe_hi & ~ctl_i.busy_n & (grace_q == G_LAST);
    hold_en   = ~strobe_hi;
    commit_o  = w_end & ~nv_busy_i & ~low_v_i;

    wr_act_d = wr_act_q;
    if (w_start)                wr_act_d = 1'b1;
    else if (w_end | grace_hit) wr_act_d = 1'b0;

    grace_d = grace_q;
    if (!wr_act_q || strobe_hi || ctl_i.busy_n || grace_hit) grace_d = '0;
    else                                                     grace_d = grace_q + 1'b1;

    blind_d = blind_q;
    if (ctl_i.ce_n)                  blind_d = 1'b0;
    else if (ce_q && !ctl_i.we_n)    blind_d = 1'b1;

    if (!ctl_i.busy_n || nv_busy_i) mode = M_INHIBIT;
    else if (ctl_i.ce_n)            mode = M_IDLE;
    else if (!ctl_i.we_n)           mode = M_WRITE;
    else if (!ctl_i.oe_n)           mode = M_READ;
    else                            mode = M_IDLE;

    rd_en_o = (mode == M_READ) & ~blind_d & ~wr_act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_act_q <= 1'b0;
      strobe_q <= 1'b1;
      ce_q     <= 1'b1;
      blind_q  <= 1'b0;
      grace_q  <= '0;
    end else begin
      wr_act_q <= wr_act_d;
      strobe_q <= strobe_hi;
      ce_q     <= ctl_i.ce_n;
      blind_q  <= blind_d;
      grace_q  <= grace_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_addr_q <= '0;
      hold_data_q <= '0;
    end else if (hold_en) begin
      hold_addr_q <= addr_i;
      hold_data_q <= data_i;
    end
  end

  assign waddr_o = hold_addr_q;
  assign wdata_o = hold_data_q;

  // R2
  commit_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |=> !commit_o);
  // R7
  start_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_act_q) |-> ($past(ctl_i.busy_n) && !$past(low_v_i) && !$past(nv_busy_i)));
  // R6
  grace_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_act_q |-> grace_q <= G_LAST);
  // R8
  flags_block_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_o |-> (!low_v_i && !nv_busy_i));
  // R5
  no_drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_o |-> !wr_act_q);
endmodule

// File: rtl/nvp_port.sv
module nvp_port
  import nvp_pkg::*;
#(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned GRACE_CYC = 125
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] dq_i,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe_o,
  input  logic          ce_n_i,
  input  logic          we_n_i,
  input  logic          oe_n_i,
  input  logic          busy_n_i,
  input  logic          nv_busy_i,
  input  logic          low_v_i,
  output logic          wr_done_o
);
  localparam int unsigned CTLW = $bits(ctl_t);
  localparam int unsigned SW   = CTLW + AW + DW;
  localparam logic [SW-1:0] S_RST = {{CTLW{1'b1}}, {(AW + DW){1'b0}}};

  ctl_t          ctl_s;
  logic [AW-1:0] addr_s, waddr;
  logic [DW-1:0] data_s, wdata;
  logic [SW-1:0] sync_d, sync_q;
  logic          commit;

  assign sync_d = {ce_n_i, we_n_i, oe_n_i, busy_n_i, addr_i, dq_i};
  assign {ctl_s, addr_s, data_s} = sync_q;

  nvp_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(S_RST)) i_sync (
    .clk(clk), .rst_n(rst_n), .d_i(sync_d), .q_o(sync_q)
  );

  nvp_ctrl #(.AW(AW), .DW(DW), .GRACE_CYC(GRACE_CYC)) i_ctrl (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl_s), .nv_busy_i(nv_busy_i),
    .low_v_i(low_v_i), .addr_i(addr_s), .data_i(data_s),
    .rd_en_o(dq_oe_o), .commit_o(commit), .waddr_o(waddr), .wdata_o(wdata)
  );

  nvp_array #(.AW(AW), .DW(DW)) i_array (
    .clk(clk), .rst_n(rst_n), .we_i(commit), .waddr_i(waddr),
    .wdata_i(wdata), .raddr_i(addr_s), .rdata_o(dq_o)
  );

  assign wr_done_o = commit;

  // R4
  busy_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_s.busy_n |-> !dq_oe_o);
  // R3
  deselect_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_s.ce_n |-> !dq_oe_o);
endmodule

// File: tb/test_nvp_port.sv
`timescale 1ns/1ps
module test_nvp_port;
  localparam int GRACE = 125;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] addr;
  logic [7:0]  din, dout;
  logic        dq_oe, ce_n, we_n, oe_n, busy_n, nv, lv, wr_done;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 0;

  always #4 clk = ~clk;

  nvp_port #(.GRACE_CYC(GRACE)) i_nvp_port (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .dq_i(din), .dq_o(dout),
    .dq_oe_o(dq_oe), .ce_n_i(ce_n), .we_n_i(we_n), .oe_n_i(oe_n),
    .busy_n_i(busy_n), .nv_busy_i(nv), .low_v_i(lv), .wr_done_o(wr_done)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_pins();
    ce_n = 1; we_n = 1; oe_n = 1;
  endtask

  task automatic do_write(input logic [10:0] a, input logic [7:0] d, input bit by_ce,
                          input bit exp_done, input string req);
    addr = a; din = d; oe_n = 1; ce_n = 0; we_n = 0;
    tick(3);
    if (by_ce) ce_n = 1; else we_n = 1;
    tick(2);
    chk(req, wr_done, exp_done);
    tick(1);
    chk(req, wr_done, 0);
    idle_pins();
    tick(2);
  endtask

  task automatic do_read(input logic [10:0] a, input bit exp_oe, input logic [7:0] exp_d,
                         input string req);
    addr = a; we_n = 1; ce_n = 0; oe_n = 0;
    tick(2);
    chk(req, dq_oe, exp_oe);
    if (exp_oe) chk(req, dout, exp_d);
    idle_pins();
    tick(2);
  endtask

  task automatic t_reset();
    chk("R11", dq_oe, 0);
    chk("R11", wr_done, 0);
    do_read(11'h005, 1, 8'h00, "R11");
    do_read(11'h7FF, 1, 8'h00, "R11");
  endtask

  task automatic t_basic();
    do_write(11'h0A5, 8'h12, 0, 1, "R2");
    do_read(11'h0A5, 1, 8'h12, "R1");
    // R2: output enable held low during a select-controlled write
    addr = 11'h7FF; din = 8'h3C; oe_n = 0; ce_n = 0; we_n = 0;
    tick(3); ce_n = 1; tick(2);
    chk("R2", wr_done, 1);
    tick(1); idle_pins(); tick(2);
    do_write(11'h000, 8'hC3, 1, 1, "R10");
    do_read(11'h7FF, 1, 8'h3C, "R10");
    do_read(11'h000, 1, 8'hC3, "R10");
  endtask

  task automatic t_deselect();
    addr = 11'h0A5; ce_n = 1; oe_n = 0; we_n = 1;
    tick(2);
    chk("R3", dq_oe, 0);
    idle_pins(); tick(2);
  endtask

  task automatic t_busy_read();
    busy_n = 0; addr = 11'h0A5; ce_n = 0; oe_n = 0; we_n = 1;
    tick(3);
    chk("R4", dq_oe, 0);
    busy_n = 1; tick(2);
    chk("R4", dq_oe, 1);
    idle_pins(); tick(2);
  endtask

  task automatic t_blind();
    addr = 11'h050; din = 8'h5A; oe_n = 0; ce_n = 0; we_n = 0;
    tick(3); we_n = 1; tick(4);
    chk("R5", dq_oe, 0);
    ce_n = 1; tick(2);
    chk("R5", dq_oe, 0);
    do_read(11'h050, 1, 8'h5A, "R5");
  endtask

  task automatic t_latency();
    addr = 11'h0A5; we_n = 1; ce_n = 0; oe_n = 0;
    tick(1);
    chk("R12", dq_oe, 0);
    tick(1);
    chk("R12", dq_oe, 1);
    idle_pins(); tick(2);
  endtask

  task automatic t_grace();
    int cnt;
    addr = 11'h020; din = 8'h55; ce_n = 0; we_n = 0;
    tick(3); busy_n = 0; tick(3); we_n = 1; tick(2);
    chk("R6", wr_done, 1);
    tick(1); idle_pins(); busy_n = 1; tick(3);
    do_read(11'h020, 1, 8'h55, "R6");
    cnt = 0;
    addr = 11'h021; din = 8'h66; ce_n = 0; we_n = 0;
    tick(3); busy_n = 0;
    for (int i = 0; i < GRACE + 10; i++) begin tick(1); cnt += int'(wr_done); end
    we_n = 1;
    for (int i = 0; i < 4; i++) begin tick(1); cnt += int'(wr_done); end
    chk("R6", cnt, 0);
    idle_pins(); busy_n = 1; tick(3);
    do_read(11'h021, 1, 8'h00, "R6");
  endtask

  task automatic t_late_start();
    int cnt = 0;
    busy_n = 0; tick(3);
    addr = 11'h022; din = 8'h77; ce_n = 0; we_n = 0;
    tick(3); busy_n = 1; tick(3); we_n = 1;
    for (int i = 0; i < 4; i++) begin tick(1); cnt += int'(wr_done); end
    chk("R7", cnt, 0);
    idle_pins(); tick(2);
    do_read(11'h022, 1, 8'h00, "R7");
  endtask

  task automatic t_low_v();
    lv = 1;
    do_write(11'h023, 8'h88, 0, 0, "R8");
    lv = 0;
    do_read(11'h023, 1, 8'h00, "R8");
  endtask

  task automatic t_nv();
    do_write(11'h024, 8'h99, 0, 1, "R9");
    nv = 1;
    do_read(11'h024, 0, 8'h00, "R9");
    do_write(11'h024, 8'hAA, 0, 0, "R9");
    nv = 0;
    do_read(11'h024, 1, 8'h99, "R9");
  endtask

  initial begin
    rst_n = 0; addr = '0; din = '0; busy_n = 1; nv = 0; lv = 0;
    idle_pins();
    tick(4);
    rst_n = 1;
    tick(3);
    t_reset();
    t_basic();
    t_deselect();
    t_busy_read();
    t_blind();
    t_latency();
    t_grace();
    t_late_start();
    t_low_v();
    t_nv();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule